// File: doc/BRIEF.md
# Host Bridge CPU Address Decoder

This block sits on the CPU side of a PCI host bridge and classifies every CPU bus request into one of four windows: PCI I/O space, the direct configuration window, PCI memory space, or the single interrupt-acknowledge byte. Requests outside all of them, and requests with an unsupported size, are flagged as a decode miss.

For a hit, the block also produces the address for the PCI side and the byte lanes the request touches. I/O offsets are turned into PCI I/O addresses. A level input picks how this is done: a dense 64 KB map, or a sparse map that gathers scattered offset bits into a compact port number. Direct configuration offsets become a configuration address: the position of the lowest set device-select bit is encoded above the register offset. Translated I/O addresses that land on the indirect configuration index or data register are flagged, so a downstream configuration engine can claim them.

The request is sampled on a valid strobe. All results are registered and appear one clock later.

Top module: `hb_addr_decoder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `req_valid` is low, the result outputs keep their last values.
- R2: `out_region` is one-hot: bit 0 means I/O (0x80000000 to 0x807FFFFF), bit 1 means direct configuration (0x80800000 to 0x80BFFFFF), bit 2 means memory (0xC0000000 to 0xFEFFFFFF), and bit 3 means interrupt acknowledge (0xBFFFFFF0).
- R3: Any of the following sets `out_miss`, with `out_region`, `out_addr`, `out_be` and `out_cfgreg` all zero: an address in no window, a size code of 3, or an interrupt-acknowledge address with a size other than one byte.
- R4: With `io_sparse`=0, the I/O result is the low 16 bits of the offset from 0x80000000.
- R5: With `io_sparse`=1, the I/O result has offset bits 4:0 in bits 4:0 and offset bits 22:12 in bits 15:5.
- R6: For a configuration hit, bits 10:0 of the result equal offset bits 10:0. Bits 14:11 hold the index k (0 to 10) of the lowest set offset bit among 21:11, taken as offset bit 11+k, or 11 if none of those bits is set. All higher bits are zero.
- R7: For a memory hit, the result is the address minus 0xC0000000.
- R8: An interrupt-acknowledge hit gives an `out_addr` of zero.
- R9: The size code is 0, 1 or 2 for 1, 2 or 4 bytes. On a hit, `out_be` is the byte mask for that size shifted left by address bits 1:0. Bits 7:4 show the lanes that spill into the next 32-bit word when the request is unaligned.
- R10: On an I/O hit, `out_cfgreg` is 01 when the translated address is 0xCF8 to 0xCFB and 10 when it is 0xCFC to 0xCFF. Otherwise it is 00. `out_cfgreg` is 00 for any other region.
- R11: After reset, `out_valid`, `out_miss`, `out_region`, `out_addr`, `out_be` and `out_cfgreg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | CPU byte address |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| io_sparse | input | 1 | I/O map select: 0 = dense, 1 = sparse |
| out_valid | output | 1 | Result valid |
| out_region | output | 4 | One-hot window select |
| out_miss | output | 1 | Request hit no window or was invalid |
| out_addr | output | 32 | Translated address |
| out_be | output | 8 | Byte lanes, with bits 7:4 being the spill into the next word |
| out_cfgreg | output | 2 | Indirect configuration register hit (01 = index, 10 = data) |

## Verification
Each result is due on the first rising edge after the request is driven. The bench drives a request on a falling edge and samples all outputs on the next falling edge, which falls half a period after the edge that registers the result. For the hold behaviour, the bench drops the strobe, changes the address and samples one falling edge later. It expects `out_valid` to be low and the earlier results to be unchanged.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int RGN_N    = 4;
  localparam int RGN_IO   = 0;
  localparam int RGN_CFG  = 1;
  localparam int RGN_MEM  = 2;
  localparam int RGN_IACK = 3;
  localparam int DEVSEL_LO = 11;
  localparam int DEVSEL_N  = 11;

  // direct configuration: register offset kept, lowest device-select bit index encoded above it
  function automatic logic [31:0] f_cfg_addr(input logic [31:0] off);
    logic [3:0] idx;
    logic       seen;
    idx  = 4'(DEVSEL_N);
    seen = 1'b0;
    for (int i = 0; i < DEVSEL_N; i++) begin
      if (!seen && off[DEVSEL_LO + i]) begin
        idx  = 4'(i);
        seen = 1'b1;
      end
    end
    return {17'd0, idx, off[10:0]};
  endfunction

  function automatic logic [31:0] f_io_dense(input logic [31:0] off);
    return {16'd0, off[15:0]};
  endfunction

  // sparse map: bits 26:12 close up onto bits 19:5, bits 4:0 stay
  function automatic logic [31:0] f_io_sparse(input logic [31:0] off);
    return {12'd0, off[26:12], off[4:0]};
  endfunction

  function automatic logic [7:0] f_lanes(input logic [1:0] sz, input logic [1:0] lo);
    logic [7:0] m;
    case (sz)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'h00;
    endcase
    return m << lo;
  endfunction
endpackage

// File: rtl/hbd_window_sel.sv
module hbd_window_sel #(
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter logic [31:0] IO_SPAN   = 32'h0080_0000,
  parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
  parameter logic [31:0] CFG_SPAN  = 32'h0040_0000,
  parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
  parameter logic [31:0] MEM_SPAN  = 32'h3F00_0000,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  output logic        hit_io,
  output logic        hit_cfg,
  output logic        hit_mem,
  output logic        hit_iack
);
  logic size_ok;
  assign size_ok  = (size != 2'd3);
  assign hit_io   = size_ok && (addr >= IO_BASE)  && ((addr - IO_BASE)  < IO_SPAN);
  assign hit_cfg  = size_ok && (addr >= CFG_BASE) && ((addr - CFG_BASE) < CFG_SPAN);
  assign hit_mem  = size_ok && (addr >= MEM_BASE) && ((addr - MEM_BASE) < MEM_SPAN);
  assign hit_iack = (size == 2'd0) && (addr == IACK_ADDR);
endmodule

// File: rtl/hbd_xlate.sv
module hbd_xlate
  import hbd_pkg::*;
#(
  parameter logic [31:0] IO_BASE  = 32'h8000_0000,
  parameter logic [31:0] CFG_BASE = 32'h8080_0000,
  parameter logic [31:0] MEM_BASE = 32'hC000_0000,
  parameter logic [31:0] IDX_REG  = 32'h0000_0CF8,
  parameter logic [31:0] DAT_REG  = 32'h0000_0CFC
) (
  input  logic [31:0]      addr,
  input  logic             sparse,
  input  logic [RGN_N-1:0] rgn,
  output logic [31:0]      xaddr,
  output logic [1:0]       cfgreg
);
  logic [31:0] io_addr;
  always_comb begin
    io_addr = sparse ? f_io_sparse(addr - IO_BASE) : f_io_dense(addr - IO_BASE);
    xaddr   = 32'd0;
    cfgreg  = 2'b00;
    if (rgn[RGN_IO]) begin
      xaddr     = io_addr;
      cfgreg[0] = (io_addr[31:2] == IDX_REG[31:2]);
      cfgreg[1] = (io_addr[31:2] == DAT_REG[31:2]);
    end else if (rgn[RGN_CFG]) begin
      xaddr = f_cfg_addr(addr - CFG_BASE);
    end else if (rgn[RGN_MEM]) begin
      xaddr = addr - MEM_BASE;
    end
  end
endmodule

// File: rtl/hb_addr_decoder.sv
module hb_addr_decoder
  import hbd_pkg::*;
#(
  parameter logic [31:0] IO_BASE   = 32'h8000_0000,
  parameter logic [31:0] IO_SPAN   = 32'h0080_0000,
  parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
  parameter logic [31:0] CFG_SPAN  = 32'h0040_0000,
  parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
  parameter logic [31:0] MEM_SPAN  = 32'h3F00_0000,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        io_sparse,
  output logic        out_valid,
  output logic [3:0]  out_region,
  output logic        out_miss,
  output logic [31:0] out_addr,
  output logic [7:0]  out_be,
  output logic [1:0]  out_cfgreg
);
  logic             w_hit_io, w_hit_cfg, w_hit_mem, w_hit_iack;
  logic [RGN_N-1:0] w_rgn;
  logic             w_miss;
  logic [31:0]      w_xaddr;
  logic [1:0]       w_cfgreg;
  logic [7:0]       w_be;

  hbd_window_sel #(
    .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN), .CFG_BASE(CFG_BASE), .CFG_SPAN(CFG_SPAN),
    .MEM_BASE(MEM_BASE), .MEM_SPAN(MEM_SPAN), .IACK_ADDR(IACK_ADDR)
  ) u_sel (
    .addr(req_addr), .size(req_size),
    .hit_io(w_hit_io), .hit_cfg(w_hit_cfg), .hit_mem(w_hit_mem), .hit_iack(w_hit_iack)
  );

  assign w_rgn  = {w_hit_iack, w_hit_mem, w_hit_cfg, w_hit_io};
  assign w_miss = (w_rgn == '0);

  hbd_xlate #(
    .IO_BASE(IO_BASE), .CFG_BASE(CFG_BASE), .MEM_BASE(MEM_BASE)
  ) u_xl (
    .addr(req_addr), .sparse(io_sparse), .rgn(w_rgn),
    .xaddr(w_xaddr), .cfgreg(w_cfgreg)
  );

  assign w_be = w_miss ? 8'h00 : f_lanes(req_size, req_addr[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_region <= '0;
      out_miss   <= 1'b0;
      out_addr   <= '0;
      out_be     <= '0;
      out_cfgreg <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_region <= w_rgn;
        out_miss   <= w_miss;
        out_addr   <= w_xaddr;
        out_be     <= w_be;
        out_cfgreg <= w_cfgreg;
      end
    end
  end
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic        io_sparse,
  input logic        hit_io,
  input logic        hit_iack,
  input logic        out_valid,
  input logic [3:0]  out_region,
  input logic        out_miss,
  input logic [31:0] out_addr,
  input logic [7:0]  out_be,
  input logic [1:0]  out_cfgreg
);
  // R2 R3: exactly one of region bits or miss
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_region, out_miss}) == 1));
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_region)));
  assert_dense_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_io && !io_sparse) |=> (out_addr[31:16] == 16'd0));
  assert_iack_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_iack) |=> (out_region[3] && out_addr == 32'd0));
  assert_bad_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |=> (out_miss && out_be == 8'h00));
  assert_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> (out_be != 8'h00));
  assert_cfgreg_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cfgreg != 2'b00) |-> (out_region == 4'b0001 && $onehot0(out_cfgreg)));
endmodule

bind hb_addr_decoder hbd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .io_sparse(io_sparse), .hit_io(w_hit_io), .hit_iack(w_hit_iack),
  .out_valid(out_valid), .out_region(out_region), .out_miss(out_miss),
  .out_addr(out_addr), .out_be(out_be), .out_cfgreg(out_cfgreg)
);

// File: tb/tb_hb_addr_decoder.sv
`timescale 1ns/1ps
module tb_hb_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        io_sparse = 1'b0;
  logic        out_valid, out_miss;
  logic [3:0]  out_region;
  logic [31:0] out_addr;
  logic [7:0]  out_be;
  logic [1:0]  out_cfgreg;
  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  hb_addr_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .io_sparse(io_sparse), .out_valid(out_valid),
    .out_region(out_region), .out_miss(out_miss), .out_addr(out_addr),
    .out_be(out_be), .out_cfgreg(out_cfgreg)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic [1:0] sz, input logic sp,
                       output logic [3:0] rg, output logic [31:0] xa,
                       output logic [7:0] be, output logic [1:0] cr, output logic ms);
    logic [31:0] off, io;
    int k;
    rg = 4'b0000; xa = 0; be = 0; cr = 0;
    if (sz != 2'd3) begin
      if (a >= 32'h8000_0000 && a <= 32'h807F_FFFF) rg = 4'b0001;
      else if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) rg = 4'b0010;
      else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) rg = 4'b0100;
      else if (a == 32'hBFFF_FFF0 && sz == 2'd0) rg = 4'b1000;
    end
    ms = (rg == 4'b0000);
    if (rg == 4'b0001) begin
      off = a - 32'h8000_0000;
      io  = sp ? {16'd0, off[22:12], off[4:0]} : (off % 32'h10000);
      xa  = io;
      if (io >= 32'hCF8 && io <= 32'hCFB) cr = 2'b01;
      if (io >= 32'hCFC && io <= 32'hCFF) cr = 2'b10;
    end else if (rg == 4'b0010) begin
      off = a - 32'h8080_0000;
      k = 11;
      for (int j = 10; j >= 0; j--) if (off[11+j]) k = j;
      xa = (off & 32'h7FF) + k * 2048;
    end else if (rg == 4'b0100) begin
      xa = a + 32'h4000_0000;
    end
    if (!ms) be = 8'((2 ** (2 ** sz)) - 1) * 8'(2 ** a[1:0]);
  endtask

  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic sp, input string tag);
    logic [3:0] rg; logic [31:0] xa; logic [7:0] be; logic [1:0] cr; logic ms;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; io_sparse = sp;
    model(a, sz, sp, rg, xa, be, cr, ms);
    @(negedge clk);
    req_valid = 1'b0;
    cmp(tag, "valid", 32'(out_valid), 32'd1);
    cmp(tag, "region", 32'(out_region), 32'(rg));
    cmp(tag, "miss", 32'(out_miss), 32'(ms));
    cmp(tag, "addr", out_addr, xa);
    cmp(tag, "be", 32'(out_be), 32'(be));
    cmp(tag, "cfgreg", 32'(out_cfgreg), 32'(cr));
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return v * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] hold_addr;
    logic [3:0]  hold_rgn;
    #12;
    // R11 reset state
    cmp("R11", "valid", 32'(out_valid), 0);
    cmp("R11", "miss", 32'(out_miss), 0);
    cmp("R11", "region", 32'(out_region), 0);
    cmp("R11", "addr", out_addr, 0);
    cmp("R11", "be", 32'(out_be), 0);
    cmp("R11", "cfgreg", 32'(out_cfgreg), 0);
    rst_n = 1'b1;
    // R2 R3 window boundaries with every size code and both maps
    begin
      logic [31:0] edges [14] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h807F_FFFF,
        32'h8080_0000, 32'h80BF_FFFF, 32'h80C0_0000, 32'hBFFF_FFEF, 32'hBFFF_FFF0,
        32'hBFFF_FFF1, 32'hBFFF_FFFF, 32'hC000_0000, 32'hFEFF_FFFF, 32'hFF00_0000};
      for (int e = 0; e < 14; e++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < 2; p++) run(edges[e], 2'(s), 1'(p), "R2_R3");
    end
    // R8 interrupt acknowledge, and R3 for wider sizes there
    for (int s = 0; s < 4; s++) run(32'hBFFF_FFF0, 2'(s), 1'b0, "R8_R3");
    // R9 lanes over sizes and alignments
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        run(32'hC000_1000 + 32'(o), 2'(s), 1'b0, "R9");
        run(32'h8000_0100 + 32'(o), 2'(s), 1'b1, "R9");
      end
    // R6 each device-select bit alone, with pairs, and with none
    for (int b = 11; b <= 21; b++) begin
      run(32'h8080_0000 + (32'd1 << b) + 32'h2A5, 2'd2, 1'b0, "R6");
      run(32'h8080_0000 + (32'd1 << b) + 32'h20_0000 + 32'h7FF, 2'd0, 1'b0, "R6");
    end
    run(32'h8080_0123, 2'd1, 1'b0, "R6");
    // R10 indirect configuration register neighbourhood, dense and sparse
    for (int i = 32'hCF0; i < 32'hD08; i++) begin
      run(32'h8000_0000 + 32'(i), 2'd0, 1'b0, "R10");
      run(32'h8000_0000 + ((32'(i) >> 5) << 12) + (32'(i) & 32'h1F), 2'd0, 1'b1, "R10");
    end
    run(32'h8080_0CF8, 2'd2, 1'b0, "R10");
    // R4 R5 R7 pseudo-random sweeps inside the windows
    for (int i = 0; i < 400; i++) begin
      lcg = nxt(lcg);
      run(32'h8000_0000 + (lcg & 32'h7F_FFFF), 2'(lcg[31:30] % 3), 1'b0, "R4");
      lcg = nxt(lcg);
      run(32'h8000_0000 + (lcg & 32'h7F_FFFF), 2'(lcg[31:30] % 3), 1'b1, "R5");
      lcg = nxt(lcg);
      run(32'h8080_0000 + (lcg & 32'h3F_FFFF), 2'(lcg[31:30] % 3), 1'b0, "R6");
      lcg = nxt(lcg);
      run(32'hC000_0000 + (lcg % 32'h3F00_0000), 2'(lcg[31:30] % 3), 1'b0, "R7");
    end
    // R1 hold while idle
    run(32'hC012_3456, 2'd1, 1'b0, "R1");
    hold_addr = out_addr; hold_rgn = out_region;
    req_addr = 32'h8080_0800; req_size = 2'd2;
    @(negedge clk);
    cmp("R1", "valid idle", 32'(out_valid), 0);
    cmp("R1", "addr held", out_addr, hold_addr);
    cmp("R1", "region held", 32'(out_region), 32'(hold_rgn));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule